// File: doc/BRIEF.md
# Write-Protected Seconds Counter with Alarm

This peripheral keeps elapsed time as a binary count of seconds. A prescaler divides a slow-clock enable pulse (`slow_tick`, one system-clock cycle wide) into one step per second. On each step the count advances and a sticky one-second event is latched. An alarm register is compared against the value the count is about to take. When the alarm is armed, a match latches a sticky alarm event. Each event can be routed to a single level interrupt line through its own enable bit.

Software reaches the block over a simple single-cycle 32-bit register bus. Reads are combinational on the address. Writes are protected twice over. First, a key must be written to the unlock register before each store, and one accepted store spends the unlock. Second, after a store is accepted, a ready bit stays low for a fixed number of slow ticks while the value settles, and any store issued in that window is dropped. Event bits clear only when a 0 is written to them. Writing a 1 to an event bit leaves it alone, so a read-modify-write of the control word never loses an event.

Top module: `rtc_sec_alarm`

## Requirements
- R1: Reset brings the seconds, alarm, scratch, unlock state, all control fields and both event bits to 0. It leaves the ready bit at 1 and `irq` at 0.
- R2: Writing a value whose low 16 bits are 0xA55A to offset 0x3C sets the unlock state, which reads back as bit 31 of offset 0x3C. Any other value written there clears it. Writes to 0x3C are taken whether or not ready is set.
- R3: A write to any offset other than 0x3C takes effect only when the unlock state is 1 and ready is 1. Such an accepted write clears the unlock state. A write issued while locked or not ready changes nothing, and that includes the unlock state.
- R4: Ready reads 0 from the cycle after an accepted write until BUSY_TICKS slow ticks have passed. It then reads 1 again.
- R5: The control word at offset 0x00 has this layout: bit 7 ready (read-only), bit 6 one-second event, bit 5 one-second interrupt enable, bit 4 alarm event, bit 3 alarm interrupt enable, bit 2 alarm arm, bit 0 run. Bit 1 and bits 31:8 read 0.
- R6: Both event bits are sticky. A control write with 0 in an event bit clears it, and a 1 leaves it unchanged. An event arriving in the same cycle as a clearing write wins.
- R7: The alarm event is set when, with the arm bit at 1, the count steps to a value equal to the alarm register at offset 0x08.
- R8: With run at 1, the seconds register at offset 0x04 advances by one for every PRESCALE slow ticks. With run at 0, both the count and the prescaler phase hold.
- R9: The seconds, alarm and scratch (offset 0x34) registers read back what was written. A seconds write that lands in the same cycle as a step replaces the stepped value.
- R10: The one-second event is set on every step of the count.
- R11: `irq` is high exactly when (one-second event and its enable) or (alarm event and its enable).
- R12: Unmapped offsets read 0. An accepted write to one of them stores nothing but still spends the unlock and starts the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 (with bus_sel) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. A software write to the seconds register can meet a prescaler step, and a control write that clears the one-second event can meet the step that sets it. The bench provokes both by repeating unlocked stores, each after a growing number of idle cycles, with the prescaler running, so the store lands at every phase of the second. A behavioural model updates on each clock with the store taking priority for the count value and the new event taking priority over the clear. Every cycle, the model's readback and interrupt are compared with the ports.

// File: rtl/rtc_sec_alarm_pkg.sv
package rtc_sec_alarm_pkg;
   localparam int unsigned BUS_AW = 6;
   localparam int unsigned BUS_DW = 32;

   localparam logic [BUS_AW-1:0] OFS_CTRL    = 6'h00;
   localparam logic [BUS_AW-1:0] OFS_SEC     = 6'h04;
   localparam logic [BUS_AW-1:0] OFS_ALARM   = 6'h08;
   localparam logic [BUS_AW-1:0] OFS_SCRATCH = 6'h34;
   localparam logic [BUS_AW-1:0] OFS_UNLOCK  = 6'h3C;

   localparam int unsigned B_RUN    = 0;
   localparam int unsigned B_ALMARM = 2;
   localparam int unsigned B_ALMIE  = 3;
   localparam int unsigned B_ALMEV  = 4;
   localparam int unsigned B_SECIE  = 5;
   localparam int unsigned B_SECEV  = 6;
   localparam int unsigned B_READY  = 7;

   localparam logic [15:0] UNLOCK_KEY = 16'hA55A;

   typedef struct packed {
      logic sec_ie;
      logic alm_ie;
      logic alm_arm;
      logic run;
   } ctl_t;
endpackage

// File: rtl/rtc_wgate.sv
module rtc_wgate #(
   parameter int unsigned BUSY_TICKS = 2,
   parameter bit          UNLOCK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_tick,
   input  logic key_wr,
   input  logic key_ok,
   input  logic reg_wr,
   output logic accept,
   output logic ready,
   output logic wen
);
   localparam int unsigned BW = $clog2(BUSY_TICKS + 1);

   logic [BW-1:0] busy_q;

   assign ready  = (busy_q == '0);
   assign accept = reg_wr & wen & ready;

   generate
      if (UNLOCK_EN) begin : g_key
         logic wen_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      wen_q <= 1'b0;
            else if (key_wr) wen_q <= key_ok;
            else if (accept) wen_q <= 1'b0;
         end
         assign wen = wen_q;
      end else begin : g_open
         logic unused_key;
         assign unused_key = key_wr ^ key_ok;
         assign wen = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                        busy_q <= '0;
      else if (accept)                   busy_q <= BW'(BUSY_TICKS);
      else if (slow_tick && !ready)      busy_q <= busy_q - 1'b1;
   end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int unsigned PRESCALE = 32768,
   parameter int unsigned SEC_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             run,
   input  logic             ld,
   input  logic [SEC_W-1:0] ld_val,
   input  logic [SEC_W-1:0] alm_val,
   input  logic             alm_arm,
   output logic [SEC_W-1:0] sec,
   output logic             step,
   output logic             alm_hit
);
   localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   logic [SEC_W-1:0] sec_q;
   logic [SEC_W-1:0] sec_inc;

   generate
      if (PRESCALE == 1) begin : g_direct
         assign step = slow_tick & run;
      end else begin : g_div
         logic [PRE_W-1:0] pre_q;
         logic             wrap;
         assign wrap = (pre_q == PRE_W'(PRESCALE - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)                pre_q <= '0;
            else if (slow_tick && run) pre_q <= wrap ? '0 : pre_q + 1'b1;
         end
         assign step = slow_tick & run & wrap;
      end
   endgenerate

   assign sec_inc = sec_q + 1'b1;
   assign alm_hit = step & alm_arm & (sec_inc == alm_val);

   always_ff @(posedge clk) begin
      if (!rst_n)    sec_q <= '0;
      else if (ld)   sec_q <= ld_val;
      else if (step) sec_q <= sec_inc;
   end

   assign sec = sec_q;
endmodule

// File: rtl/rtc_ctrlreg.sv
module rtc_ctrlreg
   import rtc_sec_alarm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wbyte,
   input  logic       set_sec,
   input  logic       set_alm,
   output ctl_t       ctl,
   output logic       sec_ev,
   output logic       alm_ev
);
   ctl_t ctl_q;
   logic sec_ev_q, alm_ev_q;
   logic clr_sec, clr_alm;
   logic unused_bits;

   assign unused_bits = wbyte[B_READY] ^ wbyte[1];
   assign clr_sec = wr & ~wbyte[B_SECEV];
   assign clr_alm = wr & ~wbyte[B_ALMEV];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr) begin
         ctl_q.run     <= wbyte[B_RUN];
         ctl_q.alm_arm <= wbyte[B_ALMARM];
         ctl_q.alm_ie  <= wbyte[B_ALMIE];
         ctl_q.sec_ie  <= wbyte[B_SECIE];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_ev_q <= 1'b0;
         alm_ev_q <= 1'b0;
      end else begin
         sec_ev_q <= (sec_ev_q & ~clr_sec) | set_sec;
         alm_ev_q <= (alm_ev_q & ~clr_alm) | set_alm;
      end
   end

   assign ctl    = ctl_q;
   assign sec_ev = sec_ev_q;
   assign alm_ev = alm_ev_q;
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
   import rtc_sec_alarm_pkg::*;
#(
   parameter int unsigned PRESCALE   = 32768,
   parameter int unsigned BUSY_TICKS = 2,
   parameter bit          UNLOCK_EN  = 1'b1,
   parameter int unsigned SEC_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              irq
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (BUSY_TICKS < 1) begin : g_bad_busy
         $error("BUSY_TICKS must be at least 1");
      end
      if (SEC_W < 1 || SEC_W > BUS_DW) begin : g_bad_secw
         $error("SEC_W must lie in 1..32");
      end
   endgenerate

   logic key_wr, key_ok, reg_wr;
   logic acc_w, rdy_w, wen_w;
   logic wr_ctrl_w, wr_sec_w, wr_alm_w, wr_scr_w;
   logic [SEC_W-1:0] sec_w;
   logic step_w, hit_w;
   ctl_t ctl_q;
   logic sec_ev_w, alm_ev_w;
   logic [SEC_W-1:0]  alarm_q;
   logic [BUS_DW-1:0] scratch_q;

   assign key_wr = bus_sel & bus_we & (bus_addr == OFS_UNLOCK);
   assign key_ok = (bus_wdata[15:0] == UNLOCK_KEY);
   assign reg_wr = bus_sel & bus_we & (bus_addr != OFS_UNLOCK);

   assign wr_ctrl_w = acc_w & (bus_addr == OFS_CTRL);
   assign wr_sec_w  = acc_w & (bus_addr == OFS_SEC);
   assign wr_alm_w  = acc_w & (bus_addr == OFS_ALARM);
   assign wr_scr_w  = acc_w & (bus_addr == OFS_SCRATCH);

   rtc_wgate #(
      .BUSY_TICKS (BUSY_TICKS),
      .UNLOCK_EN  (UNLOCK_EN)
   ) u_wgate (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .key_wr    (key_wr),
      .key_ok    (key_ok),
      .reg_wr    (reg_wr),
      .accept    (acc_w),
      .ready     (rdy_w),
      .wen       (wen_w)
   );

   rtc_timebase #(
      .PRESCALE (PRESCALE),
      .SEC_W    (SEC_W)
   ) u_timebase (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .run       (ctl_q.run),
      .ld        (wr_sec_w),
      .ld_val    (bus_wdata[SEC_W-1:0]),
      .alm_val   (alarm_q),
      .alm_arm   (ctl_q.alm_arm),
      .sec       (sec_w),
      .step      (step_w),
      .alm_hit   (hit_w)
   );

   rtc_ctrlreg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ctrl_w),
      .wbyte   (bus_wdata[7:0]),
      .set_sec (step_w),
      .set_alm (hit_w),
      .ctl     (ctl_q),
      .sec_ev  (sec_ev_w),
      .alm_ev  (alm_ev_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q   <= '0;
         scratch_q <= '0;
      end else begin
         if (wr_alm_w) alarm_q   <= bus_wdata[SEC_W-1:0];
         if (wr_scr_w) scratch_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: begin
            bus_rdata[B_READY]  = rdy_w;
            bus_rdata[B_SECEV]  = sec_ev_w;
            bus_rdata[B_SECIE]  = ctl_q.sec_ie;
            bus_rdata[B_ALMEV]  = alm_ev_w;
            bus_rdata[B_ALMIE]  = ctl_q.alm_ie;
            bus_rdata[B_ALMARM] = ctl_q.alm_arm;
            bus_rdata[B_RUN]    = ctl_q.run;
         end
         OFS_SEC:     bus_rdata[SEC_W-1:0] = sec_w;
         OFS_ALARM:   bus_rdata[SEC_W-1:0] = alarm_q;
         OFS_SCRATCH: bus_rdata = scratch_q;
         OFS_UNLOCK:  bus_rdata[BUS_DW-1] = wen_w;
         default:     bus_rdata = '0;
      endcase
   end

   assign irq = (sec_ev_w & ctl_q.sec_ie) | (alm_ev_w & ctl_q.alm_ie);
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(
   parameter int unsigned SEC_W     = 32,
   parameter bit          UNLOCK_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             accept,
   input logic             ready,
   input logic             wen,
   input logic             run,
   input logic             alm_arm,
   input logic             wr_ctrl,
   input logic             wr_sec,
   input logic             wbit_secev,
   input logic [SEC_W-1:0] sec,
   input logic             sec_ev,
   input logic             alm_ev
);
   // R4
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);

   // R3
   unlock_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (UNLOCK_EN && accept) |=> !wen);

   // R8
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_sec) |=> $stable(sec));

   // R6
   secev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_ev && !(wr_ctrl && !wbit_secev)) |=> sec_ev);

   // R7
   almev_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_ev) |-> $past(alm_arm));
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(
   .SEC_W     (SEC_W),
   .UNLOCK_EN (UNLOCK_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .accept     (acc_w),
   .ready      (rdy_w),
   .wen        (wen_w),
   .run        (ctl_q.run),
   .alm_arm    (ctl_q.alm_arm),
   .wr_ctrl    (wr_ctrl_w),
   .wr_sec     (wr_sec_w),
   .wbit_secev (bus_wdata[6]),
   .sec        (sec_w),
   .sec_ev     (sec_ev_w),
   .alm_ev     (alm_ev_w)
);

// File: tb/tb_rtc_sec_alarm.sv
`timescale 1ns/1ps
module tb_rtc_sec_alarm;
   localparam int PRE  = 4;
   localparam int BUSY = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = 6'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rtc_sec_alarm #(.PRESCALE(PRE), .BUSY_TICKS(BUSY), .UNLOCK_EN(1'b1), .SEC_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // slow tick: one pulse every two clocks
   initial forever begin
      @(posedge clk); #1;
      slow_tick = ~slow_tick;
   end

   // reference model
   logic [31:0] m_sec, m_alarm, m_scr;
   bit m_run, m_ae, m_iea, m_ie1, m_f1, m_fa, m_wen;
   int m_busy, m_pre;

   always @(posedge clk) begin
      bit kw, rw, acc, step, hit;
      if (!rst_n) begin
         m_sec = 0; m_alarm = 0; m_scr = 0;
         m_run = 0; m_ae = 0; m_iea = 0; m_ie1 = 0; m_f1 = 0; m_fa = 0; m_wen = 0;
         m_busy = 0; m_pre = 0;
      end else begin
         kw = bus_sel && bus_we && bus_addr == 6'h3C;
         rw = bus_sel && bus_we && !kw;
         acc = rw && m_wen && m_busy == 0;
         step = 0;
         if (slow_tick && m_run) begin
            if (m_pre == PRE - 1) begin m_pre = 0; step = 1; end
            else m_pre++;
         end
         hit = step && m_ae && (m_sec + 32'd1) == m_alarm;
         if (step) m_sec = m_sec + 32'd1;
         if (acc) begin
            case (bus_addr)
               6'h00: begin
                  m_run = bus_wdata[0]; m_ae = bus_wdata[2]; m_iea = bus_wdata[3]; m_ie1 = bus_wdata[5];
                  if (!bus_wdata[6]) m_f1 = 0;
                  if (!bus_wdata[4]) m_fa = 0;
               end
               6'h04: m_sec = bus_wdata;
               6'h08: m_alarm = bus_wdata;
               6'h34: m_scr = bus_wdata;
               default: ;
            endcase
         end
         if (step) m_f1 = 1;
         if (hit) m_fa = 1;
         if (acc) m_busy = BUSY;
         else if (slow_tick && m_busy > 0) m_busy--;
         if (kw) m_wen = (bus_wdata[15:0] == 16'hA55A);
         else if (acc) m_wen = 0;
      end
   end

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      case (a)
         6'h00: return {24'h0, (m_busy == 0), m_f1, m_ie1, m_fa, m_iea, m_ae, 1'b0, m_run};
         6'h04: return m_sec;
         6'h08: return m_alarm;
         6'h34: return m_scr;
         6'h3C: return {m_wen, 31'h0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] a);
      case (a)
         6'h00: return "R5";
         6'h04: return "R9";
         6'h08: return "R9";
         6'h34: return "R9";
         6'h3C: return "R2";
         default: return "R12";
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (bus_rdata !== exp_rd(bus_addr)) begin
            errors++;
            $display("FAIL %s model addr=%h actual=%h expected=%h", tag_of(bus_addr), bus_addr, bus_rdata, exp_rd(bus_addr));
         end
         checks++;
         if (irq !== ((m_f1 && m_ie1) || (m_fa && m_iea))) begin
            errors++;
            $display("FAIL R11 model irq actual=%b expected=%b", irq, ((m_f1 && m_ie1) || (m_fa && m_iea)));
         end
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic chk(input logic [5:0] a, input logic [31:0] mask, input logic [31:0] expv, input string tag);
      @(posedge clk); #1;
      bus_addr = a; #0.5;
      checks++;
      if ((bus_rdata & mask) !== expv) begin
         errors++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata & mask, expv);
      end
   endtask

   task automatic chk_irq(input bit expv, input string tag);
      @(posedge clk); #1.5;
      checks++;
      if (irq !== expv) begin
         errors++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, expv);
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      @(posedge clk); #1;
      bus_addr = a; #0.5;
      v = bus_rdata;
   endtask

   task automatic wait_ready(output int cyc);
      logic [31:0] v;
      cyc = 0;
      rd(6'h00, v);
      while (!v[7] && cyc < 100) begin
         rd(6'h00, v);
         cyc++;
      end
   endtask

   task automatic safe_wr(input logic [5:0] a, input logic [31:0] d);
      int c;
      wait_ready(c);
      wr(6'h3C, 32'h0000A55A);
      wr(a, d);
   endtask

   task automatic wait_sec(input logic [31:0] target);
      logic [31:0] v;
      int n = 0;
      rd(6'h04, v);
      while (v != target && n < 200) begin
         rd(6'h04, v);
         n++;
      end
   endtask

   initial begin
      logic [31:0] held;
      int cyc;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      chk(6'h00, 32'hFFFFFFFF, 32'h00000080, "R1");
      chk(6'h04, 32'hFFFFFFFF, 32'h0, "R1");
      chk(6'h3C, 32'hFFFFFFFF, 32'h0, "R1");
      chk_irq(1'b0, "R1");

      // R3 locked write ignored
      wr(6'h04, 32'h77);
      chk(6'h04, 32'hFFFFFFFF, 32'h0, "R3");

      // R2 key and wrong key
      wr(6'h3C, 32'h0000A55A);
      chk(6'h3C, 32'hFFFFFFFF, 32'h80000000, "R2");
      wr(6'h3C, 32'h00001234);
      chk(6'h3C, 32'hFFFFFFFF, 32'h0, "R2");

      // R9 scratch, R4 busy, R3 unlock spent
      safe_wr(6'h34, 32'hDEADBEEF);
      chk(6'h00, 32'h80, 32'h0, "R4");
      chk(6'h34, 32'hFFFFFFFF, 32'hDEADBEEF, "R9");
      chk(6'h3C, 32'hFFFFFFFF, 32'h0, "R3");

      // R3 write during busy window is dropped, unlock kept
      safe_wr(6'h08, 32'h11);
      wr(6'h3C, 32'h0000A55A);
      wr(6'h08, 32'h99);
      wait_ready(cyc);
      checks++;
      if (cyc > 2 * BUSY + 2) begin
         errors++;
         $display("FAIL R4 ready delay actual=%0d expected<=%0d", cyc, 2 * BUSY + 2);
      end
      chk(6'h08, 32'hFFFFFFFF, 32'h11, "R3");
      chk(6'h3C, 32'hFFFFFFFF, 32'h80000000, "R3");

      // R12 unmapped offset
      safe_wr(6'h10, 32'h55);
      chk(6'h10, 32'hFFFFFFFF, 32'h0, "R12");
      chk(6'h3C, 32'hFFFFFFFF, 32'h0, "R12");

      // alarm and time setup, R5 layout
      safe_wr(6'h08, 32'd5);
      safe_wr(6'h04, 32'd2);
      safe_wr(6'h00, 32'hFFFFFF27);
      chk(6'h00, 32'hFFFFFF7F, 32'h25, "R5");
      chk(6'h08, 32'hFFFFFFFF, 32'd5, "R9");

      // R8 / R10 / R11 first step
      wait_sec(32'd3);
      chk(6'h04, 32'hFFFFFFFF, 32'd3, "R8");
      chk(6'h00, 32'h40, 32'h40, "R10");
      chk_irq(1'b1, "R11");

      // R7 alarm match
      wait_sec(32'd5);
      chk(6'h00, 32'h10, 32'h10, "R7");

      // R6 writing 1 keeps alarm event; R11 both enables off
      safe_wr(6'h00, 32'h15);
      chk(6'h00, 32'h10, 32'h10, "R6");
      chk_irq(1'b0, "R11");
      safe_wr(6'h00, 32'h0D);
      chk(6'h00, 32'h10, 32'h0, "R6");

      // R8 stopped counter holds
      safe_wr(6'h00, 32'h0);
      rd(6'h04, held);
      repeat (40) @(posedge clk);
      chk(6'h04, 32'hFFFFFFFF, held, "R8");

      // R9 / R6 collisions at every prescaler phase, judged by the model
      safe_wr(6'h00, 32'h21);
      for (int i = 0; i < 12; i++) begin
         repeat (i) @(posedge clk);
         if (i % 2 == 0) safe_wr(6'h04, 32'd100 * i);
         else            safe_wr(6'h00, 32'h21);
         bus_addr = (i % 2 == 0) ? 6'h04 : 6'h00;
         repeat (3) @(posedge clk);
      end
      repeat (10) @(posedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule